// File: doc/BRIEF.md
# Supply Supervisor and Fault Hiccup Sequencer

This block is the control core of an offline switching controller that powers itself from the high-voltage rail. Analog comparators report where the supply rail sits relative to five thresholds. From those flags the block decides when the high-voltage startup current source charges the rail, when the gate drive may switch, and when to issue a soft-start trigger. While the converter runs, it keeps the rail inside a window by toggling the startup source. This is the self-supply loop.

Faults stop the drive and put the block into a low-current mode. The faults are a sustained overload, an over-temperature flag, a filtered external latch request, and an undervoltage that lasts too long. The rail then goes through two complete discharge/recharge cycles before a restart is attempted. The option strap selects whether an overload latches the controller or retries. The external latch request latches in either setting. A latched controller keeps cycling through hiccup without switching. Only a fall of the rail below the logic-reset level clears it, and the hiccup loop never drives the rail that low.

All comparator and fault flags pass through a two-flop synchroniser. All time windows are counted in clock cycles and set by parameters.

Top module: `supply_sequencer`

## Requirements
- R1: While rst is high and on the first cycle after it, the outputs are hv_src_en=1, drive_en=0, low_current_en=0 and softstart_go=0. This is the startup-charging state.
- R2: In the startup state, when rail_above_start rises, drive_en goes to 1, hv_src_en goes to 0, and softstart_go pulses high for exactly one cycle.
- R3: While running, a low rail_above_min turns hv_src_en on and leaves drive_en on. hv_src_en stays on while the rail is between the minimum and start thresholds. It turns off only when rail_above_start is high.
- R4: While running, a low rail_above_uvlo removes drive_en. If the flag returns high within UV_CYCLES-1 consecutive cycles, drive_en returns and there is no soft-start pulse. If it stays low for UV_CYCLES consecutive cycles, the block enters hiccup.
- R5: overload_flag held high for OVLD_CYCLES consecutive cycles while running declares an overload fault. Shorter pulses are ignored. A pulse that drops even for one cycle restarts the count.
- R6: In hiccup, drive_en=0 and low_current_en=1. hv_src_en is 0 until rail_above_hiccup falls, then 1 until rail_above_start rises. The first arrival at the start threshold begins a second discharge. The second arrival restarts switching with one soft-start pulse.
- R7: If thermal_flag is high or the controller is latched at the second arrival, the block stays in hiccup. Every later arrival is checked again.
- R8: opt_latch=1 selects latch: an overload fault latches the controller, and the controller does not restart through any number of hiccup cycles. opt_latch=0 selects auto-retry: an overload restarts after the double hiccup.
- R9: ext_latch_in held high for LATCH_CYCLES consecutive cycles latches the controller for either value of opt_latch. Shorter pulses are ignored.
- R10: thermal_flag stops the drive and enters hiccup. It never latches: once the flag is low, the next arrival at the start threshold restarts switching.
- R11: rail_above_reset=0 clears the latch and returns the block to the startup state. This is the only way to clear a latch.
- R12: Every flag passes through two synchronising flops. An output answers a flag change on the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rail_above_start | input | 1 | Rail is above the start threshold |
| rail_above_min | input | 1 | Rail is above the minimum operating threshold |
| rail_above_uvlo | input | 1 | Rail is above the undervoltage threshold |
| rail_above_hiccup | input | 1 | Rail is above the hiccup discharge threshold |
| rail_above_reset | input | 1 | Rail is above the logic-reset level |
| overload_flag | input | 1 | Feedback is demanding more than the regulation limit |
| thermal_flag | input | 1 | Over-temperature comparator |
| ext_latch_in | input | 1 | Raw external latch request |
| opt_latch | input | 1 | 1 = overload latches, 0 = overload auto-retries (static strap) |
| hv_src_en | output | 1 | High-voltage startup current source enable |
| low_current_en | output | 1 | Low-current mode during hiccup |
| drive_en | output | 1 | Gate drive enable |
| softstart_go | output | 1 | One-cycle soft-start trigger |

## Verification
The bench builds the block with OVLD_CYCLES=8, UV_CYCLES=4 and LATCH_CYCLES=4. With these values every filter and timer can be swept pulse length by pulse length across its acceptance edge in a few cycles each. The sweeps cover undervoltage dip lengths 1 to 8, overload pulse lengths 1 to 12 and external latch pulse lengths 1 to 6. Each iteration returns to running through the real hiccup or logic-reset path, so repeated double-hiccup sequences, both option settings and the thermal recheck all run in a few thousand cycles.

// File: rtl/sup_seq_pkg.sv
package sup_seq_pkg;
  typedef enum logic [2:0] {
    ST_START   = 3'd0,
    ST_RUN     = 3'd1,
    ST_UVWAIT  = 3'd2,
    ST_HIC_DIS = 3'd3,
    ST_HIC_CHG = 3'd4
  } seq_state_t;
endpackage

// File: rtl/sup_flag_sync.sv
module sup_flag_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sup_persist.sv
module sup_persist #(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic in,
  output logic done
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !in) cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign done = in && (cnt == LAST);
endmodule

// File: rtl/supply_sequencer.sv
module supply_sequencer
  import sup_seq_pkg::*;
#(
  parameter int OVLD_CYCLES  = 1180000,
  parameter int UV_CYCLES    = 500,
  parameter int LATCH_CYCLES = 500,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rail_above_start,
  input  logic rail_above_min,
  input  logic rail_above_uvlo,
  input  logic rail_above_hiccup,
  input  logic rail_above_reset,
  input  logic overload_flag,
  input  logic thermal_flag,
  input  logic ext_latch_in,
  input  logic opt_latch,
  output logic hv_src_en,
  output logic low_current_en,
  output logic drive_en,
  output logic softstart_go
);
  localparam int NFLAG = 8;
  localparam int I_START = 7, I_MIN = 6, I_UV = 5, I_HIC = 4;
  localparam int I_RS = 3, I_OVL = 2, I_THERM = 1, I_EXT = 0;

  logic [NFLAG-1:0] flag_raw, flag_s;
  assign flag_raw = {rail_above_start, rail_above_min, rail_above_uvlo,
                     rail_above_hiccup, rail_above_reset, overload_flag,
                     thermal_flag, ext_latch_in};

  sup_flag_sync #(.W(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(flag_raw), .q(flag_s)
  );

  logic start_s, min_s, uv_s, hic_s, rs_ok, ovl_s, therm_s, ext_s;
  assign start_s = flag_s[I_START];
  assign min_s   = flag_s[I_MIN];
  assign uv_s    = flag_s[I_UV];
  assign hic_s   = flag_s[I_HIC];
  assign rs_ok   = flag_s[I_RS];
  assign ovl_s   = flag_s[I_OVL];
  assign therm_s = flag_s[I_THERM];
  assign ext_s   = flag_s[I_EXT];

  seq_state_t st_q, st_d;
  logic lat_q, lat_d, hic_cnt_q, hic_cnt_d, dss_q, dss_d, ss_d;
  logic ovl_done, uv_done, latch_hit;
  logic running, uv_watch;

  assign running  = (st_q == ST_RUN);
  assign uv_watch = !uv_s && (st_q == ST_RUN || st_q == ST_UVWAIT);

  sup_persist #(.N(OVLD_CYCLES)) u_ovld_tmr (
    .clk(clk), .rst(rst), .in(ovl_s && running), .done(ovl_done)
  );
  sup_persist #(.N(UV_CYCLES)) u_uv_filt (
    .clk(clk), .rst(rst), .in(uv_watch), .done(uv_done)
  );
  sup_persist #(.N(LATCH_CYCLES)) u_latch_filt (
    .clk(clk), .rst(rst), .in(ext_s), .done(latch_hit)
  );

  always_comb begin
    st_d      = st_q;
    lat_d     = lat_q;
    hic_cnt_d = hic_cnt_q;
    dss_d     = dss_q;
    ss_d      = 1'b0;
    if (!rs_ok) begin
      st_d      = ST_START;
      lat_d     = 1'b0;
      hic_cnt_d = 1'b0;
      dss_d     = 1'b0;
    end else begin
      if (latch_hit) lat_d = 1'b1;
      case (st_q)
        ST_START: begin
          if (start_s) begin
            hic_cnt_d = 1'b0;
            if (latch_hit || lat_q || therm_s) st_d = ST_HIC_DIS;
            else begin
              st_d  = ST_RUN;
              ss_d  = 1'b1;
              dss_d = 1'b0;
            end
          end
        end
        ST_RUN, ST_UVWAIT: begin
          if (!min_s) dss_d = 1'b1;
          else if (start_s) dss_d = 1'b0;
          if (latch_hit || therm_s || ovl_done) begin
            st_d      = ST_HIC_DIS;
            hic_cnt_d = 1'b0;
            if (ovl_done && opt_latch) lat_d = 1'b1;
          end else if (st_q == ST_RUN) begin
            if (!uv_s) st_d = ST_UVWAIT;
          end else if (uv_done) begin
            st_d      = ST_HIC_DIS;
            hic_cnt_d = 1'b0;
          end else if (uv_s) begin
            st_d = ST_RUN;
          end
        end
        ST_HIC_DIS: begin
          if (!hic_s) st_d = ST_HIC_CHG;
        end
        ST_HIC_CHG: begin
          if (start_s) begin
            if (!hic_cnt_q) begin
              hic_cnt_d = 1'b1;
              st_d      = ST_HIC_DIS;
            end else if (lat_q || latch_hit || therm_s) begin
              st_d = ST_HIC_DIS;
            end else begin
              st_d      = ST_RUN;
              ss_d      = 1'b1;
              hic_cnt_d = 1'b0;
              dss_d     = 1'b0;
            end
          end
        end
        default: st_d = ST_START;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q           <= ST_START;
      lat_q          <= 1'b0;
      hic_cnt_q      <= 1'b0;
      dss_q          <= 1'b0;
      hv_src_en      <= 1'b1;
      low_current_en <= 1'b0;
      drive_en       <= 1'b0;
      softstart_go   <= 1'b0;
    end else begin
      st_q           <= st_d;
      lat_q          <= lat_d;
      hic_cnt_q      <= hic_cnt_d;
      dss_q          <= dss_d;
      hv_src_en      <= (st_d == ST_START) || (st_d == ST_HIC_CHG) ||
                        (((st_d == ST_RUN) || (st_d == ST_UVWAIT)) && dss_d);
      low_current_en <= (st_d == ST_HIC_DIS) || (st_d == ST_HIC_CHG);
      drive_en       <= (st_d == ST_RUN);
      softstart_go   <= ss_d;
    end
  end
endmodule

// File: rtl/sup_seq_chk.sv
module sup_seq_chk
  import sup_seq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       rs_ok,
  input logic       uv_s,
  input logic       lat_q,
  input seq_state_t st_q,
  input logic       drive_en,
  input logic       low_current_en,
  input logic       softstart_go
);
  p_uv_drive_off_r4: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RUN && !uv_s) |=> !drive_en);

  p_latch_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (lat_q && rs_ok) |=> lat_q);

  p_no_drive_latched_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_en) |-> !lat_q);

  p_drive_lowcur_excl_r6: assert property (@(posedge clk) disable iff (rst)
    drive_en |-> !low_current_en);

  p_ss_single_r2: assert property (@(posedge clk) disable iff (rst)
    softstart_go |=> !softstart_go);

  p_ss_with_drive_r2: assert property (@(posedge clk) disable iff (rst)
    softstart_go |-> drive_en);

  p_logic_reset_r11: assert property (@(posedge clk) disable iff (rst)
    !rs_ok |=> (st_q == ST_START && !lat_q));
endmodule

bind supply_sequencer sup_seq_chk u_chk (
  .clk(clk), .rst(rst), .rs_ok(rs_ok), .uv_s(uv_s), .lat_q(lat_q),
  .st_q(st_q), .drive_en(drive_en), .low_current_en(low_current_en),
  .softstart_go(softstart_go)
);

// File: tb/supply_sequencer_tb.sv
module supply_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int OVLD = 8;
  localparam int UVC  = 4;
  localparam int LATC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic f_start = 0, f_min = 0, f_uv = 0, f_hic = 0, f_rs = 0;
  logic ovl = 0, therm = 0, ext = 0, opt = 0;
  logic hv_src_en, low_current_en, drive_en, softstart_go;

  int checks = 0;
  int errors = 0;
  int ss_cnt = 0;
  int ss_ref;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supply_sequencer #(.OVLD_CYCLES(OVLD), .UV_CYCLES(UVC), .LATCH_CYCLES(LATC)) u_dut (
    .clk(clk), .rst(rst),
    .rail_above_start(f_start), .rail_above_min(f_min), .rail_above_uvlo(f_uv),
    .rail_above_hiccup(f_hic), .rail_above_reset(f_rs),
    .overload_flag(ovl), .thermal_flag(therm), .ext_latch_in(ext), .opt_latch(opt),
    .hv_src_en(hv_src_en), .low_current_en(low_current_en),
    .drive_en(drive_en), .softstart_go(softstart_go)
  );

  always @(posedge clk) if (!rst && softstart_go) ss_cnt <= ss_cnt + 1;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // level = number of thresholds the rail sits above, counted from the reset level up
  task automatic set_vcc(input int level);
    f_rs    = (level >= 1);
    f_hic   = (level >= 2);
    f_uv    = (level >= 3);
    f_min   = (level >= 4);
    f_start = (level >= 5);
  endtask

  task automatic hic_cycle();
    set_vcc(1); tick(12);
    set_vcc(5); tick(6);
  endtask

  task automatic power_cycle();
    set_vcc(0); tick(5);
    set_vcc(5); tick(6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got 0 expected 1 (run did not end)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    set_vcc(0);
    tick(3);
    chk("R1 hv in reset", hv_src_en, 1);
    chk("R1 drive in reset", drive_en, 0);
    rst = 1'b0;
    tick(1);
    chk("R1 hv after reset", hv_src_en, 1);
    chk("R1 drive after reset", drive_en, 0);
    chk("R1 lowcur after reset", low_current_en, 0);
    chk("R1 softstart after reset", softstart_go, 0);

    // R2 startup
    set_vcc(5); tick(6);
    chk("R2 drive on", drive_en, 1);
    chk("R2 hv off", hv_src_en, 0);
    chk("R2 one softstart", ss_cnt, 1);

    // R12 latency and R4 immediate drive removal
    ss_ref = ss_cnt;
    set_vcc(2); tick(2);
    chk("R12 no response before third edge", drive_en, 1);
    tick(1);
    chk("R4 drive off on uv", drive_en, 0);
    chk("R4 not yet hiccup", low_current_en, 0);
    set_vcc(5); tick(6);
    chk("R4 short dip recovers", drive_en, 1);
    chk("R4 no softstart on recovery", ss_cnt, ss_ref);

    // R4 sweep over dip length
    for (int len = 1; len <= 2*UVC; len++) begin
      ss_ref = ss_cnt;
      set_vcc(2); tick(len);
      set_vcc(5); tick(8);
      chk("R4 uv sweep drive", drive_en, (len < UVC) ? 1 : 0);
      chk("R4 uv sweep hiccup", low_current_en, (len >= UVC) ? 1 : 0);
      if (len >= UVC) begin
        hic_cycle(); hic_cycle();
        chk("R6 restart after uv hiccup", drive_en, 1);
        chk("R6 softstart after uv hiccup", ss_cnt, ss_ref + 1);
      end else begin
        chk("R4 uv sweep no softstart", ss_cnt, ss_ref);
      end
    end

    // R3 self-supply window
    set_vcc(3); tick(4);
    chk("R3 hv on below min", hv_src_en, 1);
    chk("R3 drive kept", drive_en, 1);
    set_vcc(4); tick(4);
    chk("R3 hv held in window", hv_src_en, 1);
    set_vcc(5); tick(4);
    chk("R3 hv off at start", hv_src_en, 0);
    chk("R3 drive still on", drive_en, 1);

    // R5 overload sweep, auto-retry (R8)
    opt = 0;
    for (int len = 1; len <= OVLD + 4; len++) begin
      ss_ref = ss_cnt;
      ovl = 1; tick(len);
      ovl = 0; tick(4);
      chk("R5 ovl sweep drive", drive_en, (len < OVLD) ? 1 : 0);
      chk("R5 ovl sweep hiccup", low_current_en, (len >= OVLD) ? 1 : 0);
      if (len >= OVLD) begin
        hic_cycle();
        chk("R6 first arrival no restart", drive_en, 0);
        hic_cycle();
        chk("R8 auto-retry restart", drive_en, 1);
        chk("R8 auto-retry softstart", ss_cnt, ss_ref + 1);
      end
    end

    // R5 count restarts when the flag drops for one cycle
    ovl = 1; tick(OVLD - 1);
    ovl = 0; tick(1);
    ovl = 1; tick(OVLD - 1);
    ovl = 0; tick(4);
    chk("R5 broken overload ignored", drive_en, 1);

    // R6 hiccup output detail
    ss_ref = ss_cnt;
    ovl = 1; tick(OVLD + 2);
    ovl = 0; tick(3);
    chk("R6 discharge lowcur", low_current_en, 1);
    chk("R6 discharge hv off", hv_src_en, 0);
    chk("R6 discharge drive off", drive_en, 0);
    set_vcc(1); tick(4);
    chk("R6 recharge hv on", hv_src_en, 1);
    chk("R6 recharge lowcur", low_current_en, 1);
    set_vcc(5); tick(4);
    chk("R6 first arrival hv off", hv_src_en, 0);
    chk("R6 first arrival drive off", drive_en, 0);
    set_vcc(1); tick(4);
    set_vcc(5); tick(4);
    chk("R6 second arrival drive on", drive_en, 1);
    chk("R6 second arrival softstart", ss_cnt, ss_ref + 1);

    // R8 latch option, R11 clear by logic reset
    opt = 1;
    ovl = 1; tick(OVLD + 2);
    ovl = 0; tick(3);
    for (int k = 0; k < 3; k++) begin
      hic_cycle();
      chk("R8 latched stays off", drive_en, 0);
      chk("R8 latched in hiccup", low_current_en, 1);
    end
    set_vcc(0); tick(5);
    chk("R11 reset level -> startup hv", hv_src_en, 1);
    chk("R11 reset level -> lowcur off", low_current_en, 0);
    set_vcc(5); tick(6);
    chk("R11 restart after logic reset", drive_en, 1);

    // R9 external latch sweep with auto-retry option
    opt = 0;
    for (int len = 1; len <= LATC + 2; len++) begin
      ext = 1; tick(len);
      ext = 0; tick(4);
      chk("R9 ext sweep drive", drive_en, (len < LATC) ? 1 : 0);
      if (len >= LATC) begin
        hic_cycle(); hic_cycle(); hic_cycle();
        chk("R9 ext latch holds over hiccup", drive_en, 0);
        power_cycle();
        chk("R11 ext latch cleared", drive_en, 1);
      end
    end

    // R10 / R7 thermal, latch option set
    opt = 1;
    ss_ref = ss_cnt;
    therm = 1; tick(4);
    chk("R10 thermal drive off", drive_en, 0);
    chk("R10 thermal hiccup", low_current_en, 1);
    hic_cycle(); hic_cycle();
    chk("R7 thermal at second arrival stays off", drive_en, 0);
    therm = 0;
    hic_cycle();
    chk("R10 thermal not latched, restart", drive_en, 1);
    chk("R10 softstart on restart", ss_cnt, ss_ref + 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule